// File: doc/BRIEF.md
# Phase-Interleaved Video RAM Arbiter

This block lets an 8-bit processor and a raster fetch engine share one video RAM without either side ever waiting. Arbitration follows the level of the processor's two-phase clock rather than any request/grant exchange. While the phase input is low, the video fetch address drives the RAM and the returned byte is collected for the pixel shifter. While the phase input is high, the processor owns the RAM address and data paths. As a result, the display receives exactly one byte in every processor cycle.

The video RAM is visible to the processor only through an aligned window of its address map, and only while the overlay enable is set. When the overlay is clear, a processor access that falls inside the window is steered to ordinary system RAM, and the video RAM stays untouched. Software therefore maps the frame buffer in only while it redraws the display, and the rest of the time it has the full normal RAM.

The block runs from a fast system clock that samples the phase level. The video byte is published on the first system clock edge of the processor half, so it stays stable throughout that half. The scheme is sized for a processor cycle of 4 MHz.

Top module: `vram_phase_arbiter`

## Requirements
- R1: While `phi2` is 0 (video half), `vram_addr` equals `vid_addr`, `vram_oe` is 1 and `vram_we` is 0, whatever the processor inputs are.
- R2: While `phi2` is 0, `cpu_rdata_oe` is 0 and `main_sel` is 0, so the video RAM never drives the processor data bus and normal RAM is not selected.
- R3: On the first clock edge that samples `phi2` high after it was sampled low, `vid_byte` loads the `vram_rdata` value sampled at the last edge of the video half, and `vid_byte_stb` is 1 for exactly that one clock. At all other times `vid_byte` holds its value.
- R4: An overlay hit is `overlay_en` = 1 with `cpu_addr[15:10]` equal to `WIN_BASE[15:10]` (by default 0xC000 to 0xC3FF). On a hit while `phi2` is 1, `vram_addr` equals `cpu_addr[9:0]` and `main_sel` is 0.
- R5: On a hit while `phi2` is 1 with `cpu_rw` = 0 (write), `vram_we` is 1, `vram_oe` is 0 and `vram_wdata` equals `cpu_wdata`.
- R6: On a hit while `phi2` is 1 with `cpu_rw` = 1 (read), `vram_oe` is 1, `vram_we` is 0, `cpu_rdata_oe` is 1 and `cpu_rdata` equals `vram_rdata`.
- R7: While `phi2` is 1 without a hit (overlay clear, or address outside the window), `main_sel` is 1 and `vram_we`, `vram_oe` and `cpu_rdata_oe` are all 0. A write in that case leaves the video RAM contents unchanged.
- R8: After reset, `vid_byte` is 0 and `vid_byte_stb` is 0 until the first video half followed by a processor half has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the phase level |
| rst_n | input | 1 | Active-low synchronous reset |
| phi2 | input | 1 | Processor clock phase: 1 = processor half, 0 = video half |
| overlay_en | input | 1 | Maps the video RAM into the processor window when set |
| cpu_addr | input | 16 | Processor address |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Video RAM read data toward the processor |
| cpu_rdata_oe | output | 1 | Video RAM drives the processor data bus |
| main_sel | output | 1 | Processor access goes to normal RAM |
| vid_addr | input | 10 | Video fetch address |
| vid_byte | output | 8 | Latched display byte for the pixel shifter |
| vid_byte_stb | output | 1 | One-clock pulse when a new display byte is published |
| vram_addr | output | 10 | Video RAM address |
| vram_wdata | output | 8 | Video RAM write data |
| vram_rdata | input | 8 | Video RAM read data |
| vram_oe | output | 1 | Video RAM output enable |
| vram_we | output | 1 | Video RAM write strobe |

## Verification
The assertions assume that `phi2` is a clean level that stays in each half for at least one system clock, and that `vid_addr` and the video RAM read data stay steady through the video half. The bench changes inputs only at falling clock edges. It holds each half for a random 1 to 3 clocks and keeps `vid_addr` constant within a half, while the processor inputs are scrambled during the video half to show that they have no effect. The bench models the video RAM as a combinational read array with writes taken on the rising edge. It checks every display byte against its own reference copy of memory, so a stray write would show up on later video fetches.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;

    localparam int DATA_W = 8;

    // Who owns the video RAM pins this instant
    typedef enum logic [1:0] {
        ROUTE_VIDEO = 2'd0,
        ROUTE_VRAM  = 2'd1,
        ROUTE_MAIN  = 2'd2
    } route_e;

    // Registered state of the display byte latch
    typedef struct packed {
        logic              phase;
        logic [DATA_W-1:0] stage;
        logic [DATA_W-1:0] byte_out;
        logic              stb;
    } vlatch_t;

endpackage

// File: rtl/vram_arb_window.sv
module vram_arb_window #(
    parameter int                  CPU_AW   = 16,
    parameter int                  VRAM_AW  = 10,
    parameter logic [CPU_AW-1:0]   WIN_BASE = 16'hC000
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              overlay_en,
    output logic              in_window,
    output logic              hit
);
    localparam int TAG_W = CPU_AW - VRAM_AW;
    localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[CPU_AW-1:VRAM_AW];

    always_comb begin
        in_window = (cpu_addr[CPU_AW-1:VRAM_AW] == WIN_TAG);
        hit       = in_window && overlay_en;
    end
endmodule

// File: rtl/vram_arb_latch.sv
module vram_arb_latch
    import vram_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi2,
    input  logic [DATA_W-1:0] vram_rdata,
    output logic [DATA_W-1:0] vid_byte,
    output logic              vid_byte_stb
);
    vlatch_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.phase = phi2;
        st_d.stb   = 1'b0;
        if (!phi2) begin
            // keep the most recent fetch of the video half
            st_d.stage = vram_rdata;
        end
        if (phi2 && !st_q.phase) begin
            st_d.byte_out = st_q.stage;
            st_d.stb      = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase    <= 1'b1;
            st_q.stage    <= '0;
            st_q.byte_out <= '0;
            st_q.stb      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vid_byte     = st_q.byte_out;
    assign vid_byte_stb = st_q.stb;

    // R3
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_byte_stb |-> $stable(vid_byte));
    // R3
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vid_byte_stb |=> !vid_byte_stb);
endmodule

// File: rtl/vram_arb_mux.sv
module vram_arb_mux
    import vram_arb_pkg::*;
#(
    parameter int VRAM_AW = 10
) (
    input  logic               phi2,
    input  logic               hit,
    input  logic               cpu_rw,
    input  logic [VRAM_AW-1:0] cpu_addr_lo,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic [VRAM_AW-1:0] vid_addr,
    input  logic [DATA_W-1:0]  vram_rdata,
    output logic [VRAM_AW-1:0] vram_addr,
    output logic [DATA_W-1:0]  vram_wdata,
    output logic               vram_oe,
    output logic               vram_we,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cpu_rdata_oe,
    output logic               main_sel
);
    route_e route;

    always_comb begin
        if (!phi2)    route = ROUTE_VIDEO;
        else if (hit) route = ROUTE_VRAM;
        else          route = ROUTE_MAIN;
    end

    always_comb begin
        vram_addr    = vid_addr;
        vram_wdata   = cpu_wdata;
        vram_oe      = 1'b0;
        vram_we      = 1'b0;
        cpu_rdata    = vram_rdata;
        cpu_rdata_oe = 1'b0;
        main_sel     = 1'b0;
        unique case (route)
            ROUTE_VIDEO: begin
                vram_oe = 1'b1;
            end
            ROUTE_VRAM: begin
                vram_addr    = cpu_addr_lo;
                vram_oe      = cpu_rw;
                vram_we      = !cpu_rw;
                cpu_rdata_oe = cpu_rw;
            end
            default: begin
                main_sel = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/vram_phase_arbiter.sv
module vram_phase_arbiter
    import vram_arb_pkg::*;
#(
    parameter int                CPU_AW   = 16,
    parameter int                VRAM_AW  = 10,
    parameter logic [CPU_AW-1:0] WIN_BASE = 16'hC000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phi2,
    input  logic               overlay_en,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic               cpu_rw,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cpu_rdata_oe,
    output logic               main_sel,
    input  logic [VRAM_AW-1:0] vid_addr,
    output logic [DATA_W-1:0]  vid_byte,
    output logic               vid_byte_stb,
    output logic [VRAM_AW-1:0] vram_addr,
    output logic [DATA_W-1:0]  vram_wdata,
    input  logic [DATA_W-1:0]  vram_rdata,
    output logic               vram_oe,
    output logic               vram_we
);
    logic in_window;
    logic hit;

    vram_arb_window #(
        .CPU_AW  (CPU_AW),
        .VRAM_AW (VRAM_AW),
        .WIN_BASE(WIN_BASE)
    ) u_window (
        .cpu_addr  (cpu_addr),
        .overlay_en(overlay_en),
        .in_window (in_window),
        .hit       (hit)
    );

    vram_arb_mux #(
        .VRAM_AW(VRAM_AW)
    ) u_mux (
        .phi2        (phi2),
        .hit         (hit),
        .cpu_rw      (cpu_rw),
        .cpu_addr_lo (cpu_addr[VRAM_AW-1:0]),
        .cpu_wdata   (cpu_wdata),
        .vid_addr    (vid_addr),
        .vram_rdata  (vram_rdata),
        .vram_addr   (vram_addr),
        .vram_wdata  (vram_wdata),
        .vram_oe     (vram_oe),
        .vram_we     (vram_we),
        .cpu_rdata   (cpu_rdata),
        .cpu_rdata_oe(cpu_rdata_oe),
        .main_sel    (main_sel)
    );

    vram_arb_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .phi2        (phi2),
        .vram_rdata  (vram_rdata),
        .vid_byte    (vid_byte),
        .vid_byte_stb(vid_byte_stb)
    );

    // R1
    video_half_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !phi2 |-> (!vram_we && vram_oe && vram_addr == vid_addr));
    // R2
    video_half_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !phi2 |-> (!cpu_rdata_oe && !main_sel));
    // R5
    write_needs_overlay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vram_we |-> (phi2 && overlay_en && in_window && !cpu_rw));
    // R6
    drive_implies_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata_oe |-> (vram_oe && phi2 && !main_sel));
    // R7
    main_excludes_vram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_sel |-> (!vram_we && !vram_oe && !cpu_rdata_oe));
    // R3
    stb_on_phase_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vid_byte_stb |-> phi2);
endmodule

// File: tb/vram_phase_arbiter_bench.sv
module vram_phase_arbiter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phi2 = 1'b0;
    logic        overlay_en = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rw = 1'b1;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_rdata_oe;
    logic        main_sel;
    logic [9:0]  vid_addr = '0;
    logic [7:0]  vid_byte;
    logic        vid_byte_stb;
    logic [9:0]  vram_addr;
    logic [7:0]  vram_wdata;
    logic [7:0]  vram_rdata;
    logic        vram_oe;
    logic        vram_we;

    logic [7:0] ram [1024];
    logic [7:0] ref_mem [1024];

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign vram_rdata = ram[vram_addr];
    always @(posedge clk) if (vram_we) ram[vram_addr] <= vram_wdata;

    vram_phase_arbiter u_vram_phase_arbiter (
        .clk(clk), .rst_n(rst_n), .phi2(phi2), .overlay_en(overlay_en),
        .cpu_addr(cpu_addr), .cpu_rw(cpu_rw), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe), .main_sel(main_sel),
        .vid_addr(vid_addr), .vid_byte(vid_byte), .vid_byte_stb(vid_byte_stb),
        .vram_addr(vram_addr), .vram_wdata(vram_wdata), .vram_rdata(vram_rdata),
        .vram_oe(vram_oe), .vram_we(vram_we)
    );

    function automatic bit is_hit(input logic [15:0] a, input logic ov);
        return ov && (a[15:10] == 6'b110000);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // One full processor cycle: video half of lo clocks, processor half of hi clocks
    task automatic bus_cycle(input logic [15:0] a, input logic rw, input logic [7:0] wd,
                             input logic ov, input logic [9:0] va, input int lo, input int hi);
        logic [7:0] exp_byte;
        logic [7:0] held;
        bit h;
        @(negedge clk);
        phi2 = 1'b0;
        vid_addr = va;
        cpu_addr = 16'($urandom);
        cpu_rw = 1'($urandom);
        cpu_wdata = 8'($urandom);
        overlay_en = 1'($urandom);
        #1;
        chk(vram_addr == va && vram_oe && !vram_we, "R1 video half routing",
            {vram_addr, vram_oe, vram_we}, {va, 2'b10});
        chk(!cpu_rdata_oe && !main_sel, "R2 video half bus quiet",
            {cpu_rdata_oe, main_sel}, 0);
        exp_byte = ref_mem[va];
        for (int i = 0; i < lo; i++) @(negedge clk);
        chk(!vid_byte_stb, "R3 no strobe in video half", vid_byte_stb, 0);
        held = vid_byte;
        phi2 = 1'b1;
        cpu_addr = a;
        cpu_rw = rw;
        cpu_wdata = wd;
        overlay_en = ov;
        #1;
        h = is_hit(a, ov);
        if (h) begin
            chk(vram_addr == a[9:0] && !main_sel, "R4 hit routing",
                {vram_addr, main_sel}, {a[9:0], 1'b0});
            if (!rw) begin
                chk(vram_we && !vram_oe && vram_wdata == wd, "R5 hit write",
                    {vram_we, vram_oe, vram_wdata}, {2'b10, wd});
                ref_mem[a[9:0]] = wd;
            end else begin
                chk(vram_oe && !vram_we && cpu_rdata_oe && cpu_rdata == ref_mem[a[9:0]],
                    "R6 hit read", {vram_oe, vram_we, cpu_rdata_oe, cpu_rdata},
                    {3'b101, ref_mem[a[9:0]]});
            end
        end else begin
            chk(main_sel && !vram_we && !vram_oe && !cpu_rdata_oe, "R7 no hit to main RAM",
                {main_sel, vram_we, vram_oe, cpu_rdata_oe}, 4'b1000);
        end
        chk(vid_byte == held, "R3 byte held before phase edge", vid_byte, held);
        @(negedge clk);
        chk(vid_byte_stb, "R3 strobe on first processor clock", vid_byte_stb, 1);
        chk(vid_byte == exp_byte, "R3 display byte", vid_byte, exp_byte);
        for (int i = 1; i < hi; i++) begin
            @(negedge clk);
            chk(!vid_byte_stb && vid_byte == exp_byte, "R3 strobe single, byte stable",
                {vid_byte_stb, vid_byte}, {1'b0, exp_byte});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 1024; i++) begin
            ram[i] = 8'($urandom);
            ref_mem[i] = ram[i];
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8
        chk(vid_byte == 8'h00 && !vid_byte_stb, "R8 reset state", {vid_byte, vid_byte_stb}, 0);
        @(negedge clk);
        chk(vid_byte == 8'h00 && !vid_byte_stb, "R8 reset state holds", {vid_byte, vid_byte_stb}, 0);

        // Directed: window edges and overlay off
        bus_cycle(16'hC000, 1'b0, 8'hA5, 1'b1, 10'h000, 2, 2);
        bus_cycle(16'hC3FF, 1'b0, 8'h5A, 1'b1, 10'h000, 1, 1);
        bus_cycle(16'hBFFF, 1'b0, 8'h11, 1'b1, 10'h3FF, 1, 3);
        bus_cycle(16'hC400, 1'b0, 8'h22, 1'b1, 10'h3FF, 3, 1);
        bus_cycle(16'hC010, 1'b0, 8'h33, 1'b0, 10'h010, 2, 2);   // R7 ignored write
        bus_cycle(16'hC010, 1'b1, 8'h00, 1'b1, 10'h010, 2, 2);   // R7 content unchanged
        bus_cycle(16'hC3FF, 1'b1, 8'h00, 1'b1, 10'h3FF, 1, 1);   // R6 read back
        bus_cycle(16'h0000, 1'b1, 8'h00, 1'b1, 10'h3FF, 1, 1);

        // Random traffic, half of processor addresses aimed at the window
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] a;
            a = 16'($urandom);
            if ($urandom % 2 == 0) a[15:10] = 6'b110000;
            bus_cycle(a, 1'($urandom), 8'($urandom), 1'($urandom % 4 != 0),
                      10'($urandom), 1 + int'($urandom % 3), 1 + int'($urandom % 3));
        end

        // Sweep a few video addresses to expose any stray write
        for (int k = 0; k < 64; k++)
            bus_cycle(16'h0100, 1'b1, 8'h00, 1'b0, 10'(k * 16 + 3), 1, 1);

        summary();
    end
endmodule